// File: doc/BRIEF.md
# Pipelined Goldschmidt Fixed-Point Divider

The block divides a 12-bit unsigned fixed-point numerator by a 12-bit denominator by Goldschmidt iteration. Both operands carry one integer bit and eleven fraction bits and lie in [0.5, 1). Each division makes three passes through one shared pipelined multiplier. In every pass the denominator and the numerator enter on consecutive cycles and are scaled by the same factor. The first factor is a 4-bit seed read from an 8-entry reciprocal table. The two later factors are the bitwise complement of the denominator that the previous pass produced.

No central sequencer exists. Every multiplier slot carries an iteration tag, a numerator/denominator flag and a division number. The entry decoder reads the slot leaving the last stage and chooses what enters the first stage: that slot recirculated with its tag advanced, the pending numerator of a new command, or a new denominator with its table seed. Several divisions at different iterations therefore share the loop. A new command is taken whenever the first stage is free in both the cycle that holds the denominator and the cycle that holds the numerator.

A caller raises `cmd_i` with the denominator on `opnd_i` and holds both until `ready_o` is high. On the next cycle it places the numerator on `opnd_i`. The quotient appears on `q_o` together with `q_valid_o` and the division number.

Top module: `gs_divider`

## Requirements
- R1: During and right after reset, `ready_o` is 1 and `q_valid_o` is 0.
- R2: A command is accepted in a cycle where `cmd_i` and `ready_o` are both 1, and the denominator is taken from `opnd_i` in that cycle. The numerator is taken from `opnd_i` in the next cycle, and `ready_o` is 0 in that next cycle. A held command whose `ready_o` is 0 is not accepted.
- R3: The seed has the form 1.xxx. Its xxx part is floor(256/(17+2k))-8, where k is denominator bits [9:7] (bit 11 is the MSB). After the first pass the denominator lies between 0.875 minus 2 LSB and 1.0625.
- R4: A numerator enters the multiplier in the cycle after the denominator of the same division, with the same tag and with an identical factor.
- R5: The second and third passes use the bitwise complement of the denominator from the previous pass as the factor. After the third pass the denominator lies in [1 − 8 LSB, 1].
- R6: A division accepted in cycle c raises `q_valid_o` exactly in cycle c + 3·MUL_STAGES + 1, which is cycle c + 13 at the defaults. `q_valid_o` is never high at any other time.
- R7: Each product keeps bits [22:11] of the 24-bit result. For N < D the quotient is at most 2 LSB above N/D·2048 and at most 6 LSB below it.
- R8: A recirculating slot has priority over new commands. `ready_o` is 0 exactly when the first stage is taken in the next cycle or the cycle after that. The next cycle may be taken by a recirculating slot or a pending numerator; the cycle after may be taken by a recirculating slot.
- R9: Divisions overlap in the loop. Quotients leave in acceptance order, and `q_id_o` counts accepted commands modulo 2^ID_W, starting from 0 after reset.
- R10: With operands in range and N < D, no product reaches 2.0, so bit 23 of the 24-bit product is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Start request; held until accepted |
| opnd_i | input | W (12) | Denominator in the request cycle, numerator in the cycle after acceptance |
| ready_o | output | 1 | A request is accepted in this cycle if `cmd_i` is high |
| q_valid_o | output | 1 | `q_o` and `q_id_o` hold a finished quotient |
| q_o | output | W (12) | Quotient, one integer bit and 11 fraction bits |
| q_id_o | output | ID_W (4) | Number of the division that produced `q_o` |

## Verification
The range assertions on the denominator and the overflow assertion assume that both operands lie in [0x400, 0x7FF] and that the numerator is below the denominator. The stimulus draws every operand pair from that region only. The directed cases reach its corners: the smallest and largest denominator, a numerator one LSB below the denominator, and one denominator from each seed-table interval. The factor-pairing assertion assumes the caller supplies the numerator exactly one cycle after acceptance. The bench always drives it there, and it holds requests across long waits to test the priority of recirculating slots.

// File: rtl/gsd_pkg.sv
package gsd_pkg;
  typedef logic [1:0] tag_t;

  localparam tag_t TAG_FIRST = 2'd0;
  localparam tag_t TAG_LAST  = 2'd2;

  // seed fraction: truncated reciprocal of each interval midpoint, minus the leading one
  function automatic int seed_code(int idx_w, int k);
    int r;
    r = (1 << (2 * idx_w + 2)) / ((1 << (idx_w + 1)) + 2 * k + 1);
    return r - (1 << idx_w);
  endfunction
endpackage

// File: rtl/gsd_seed_rom.sv
module gsd_seed_rom #(
  parameter int W     = 12,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     fac_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PAD_W   = W - 1 - IDX_W;

  logic [IDX_W-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
    assign tbl[g] = IDX_W'(gsd_pkg::seed_code(IDX_W, g));
  end

  assign fac_o = {1'b1, tbl[idx_i], {PAD_W{1'b0}}};
endmodule

// File: rtl/gsd_entry.sv
module gsd_entry #(
  parameter int W    = 12,
  parameter int ID_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ex_vld_i,
  input  gsd_pkg::tag_t     ex_tag_i,
  input  logic              ex_num_i,
  input  logic [ID_W-1:0]   ex_id_i,
  input  logic [W-1:0]      ex_val_i,
  input  logic              acc_i,
  input  logic              pend_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic [ID_W-1:0]   new_id_i,
  input  logic [W-1:0]      opnd_i,
  input  logic [W-1:0]      seed_i,
  input  logic [W-1:0]      fac_hold_i,
  output logic              recirc_o,
  output logic              en_vld_o,
  output gsd_pkg::tag_t     en_tag_o,
  output logic              en_num_o,
  output logic [ID_W-1:0]   en_id_o,
  output logic [W-1:0]      en_val_o,
  output logic [W-1:0]      en_fac_o
);
  import gsd_pkg::*;

  assign recirc_o = ex_vld_i && (ex_tag_i != TAG_LAST);

  always_comb begin
    en_vld_o = 1'b0;
    en_tag_o = TAG_FIRST;
    en_num_o = 1'b0;
    en_id_o  = '0;
    en_val_o = '0;
    en_fac_o = fac_hold_i;
    if (recirc_o) begin
      en_vld_o = 1'b1;
      en_tag_o = ex_tag_i + 2'd1;
      en_num_o = ex_num_i;
      en_id_o  = ex_id_i;
      en_val_o = ex_val_i;
      en_fac_o = ex_num_i ? fac_hold_i : ~ex_val_i;
    end else if (pend_i) begin
      en_vld_o = 1'b1;
      en_num_o = 1'b1;
      en_id_o  = pend_id_i;
      en_val_o = opnd_i;
    end else if (acc_i) begin
      en_vld_o = 1'b1;
      en_id_o  = new_id_i;
      en_val_o = opnd_i;
      en_fac_o = seed_i;
    end
  end

  AST_ENTRY_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recirc_o |-> !(pend_i || acc_i)); // R8
endmodule

// File: rtl/gsd_mul_pipe.sv
module gsd_mul_pipe #(
  parameter int W      = 12,
  parameter int ID_W   = 4,
  parameter int STAGES = 4  // at least 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  input  gsd_pkg::tag_t     in_tag_i,
  input  logic              in_num_i,
  input  logic [ID_W-1:0]   in_id_i,
  input  logic [W-1:0]      in_a_i,
  input  logic [W-1:0]      in_b_i,
  output logic              out_vld_o,
  output gsd_pkg::tag_t     out_tag_o,
  output logic              out_num_o,
  output logic [ID_W-1:0]   out_id_o,
  output logic [W-1:0]      out_val_o,
  output logic              pk_vld_o,
  output gsd_pkg::tag_t     pk_tag_o
);
  import gsd_pkg::*;

  localparam int PW   = 2 * W;
  localparam int LAST = STAGES - 1;
  localparam int PEEK = STAGES - 2;

  logic              s_vld [STAGES];
  tag_t              s_tag [STAGES];
  logic              s_num [STAGES];
  logic [ID_W-1:0]   s_id  [STAGES];
  logic [W-1:0]      s_val [STAGES];
  logic [W-1:0]      op_b;
  logic [PW-1:0]     prod;

  assign prod = {{W{1'b0}}, s_val[0]} * {{W{1'b0}}, op_b};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) begin
        s_vld[s] <= 1'b0;
        s_tag[s] <= TAG_FIRST;
        s_num[s] <= 1'b0;
        s_id[s]  <= '0;
        s_val[s] <= '0;
      end
      op_b <= '0;
    end else begin
      s_vld[0] <= in_vld_i;
      s_tag[0] <= in_tag_i;
      s_num[0] <= in_num_i;
      s_id[0]  <= in_id_i;
      s_val[0] <= in_a_i;
      op_b     <= in_b_i;
      s_vld[1] <= s_vld[0];
      s_tag[1] <= s_tag[0];
      s_num[1] <= s_num[0];
      s_id[1]  <= s_id[0];
      s_val[1] <= prod[PW-2:W-1];
      for (int s = 2; s < STAGES; s++) begin
        s_vld[s] <= s_vld[s-1];
        s_tag[s] <= s_tag[s-1];
        s_num[s] <= s_num[s-1];
        s_id[s]  <= s_id[s-1];
        s_val[s] <= s_val[s-1];
      end
    end
  end

  assign out_vld_o = s_vld[LAST];
  assign out_tag_o = s_tag[LAST];
  assign out_num_o = s_num[LAST];
  assign out_id_o  = s_id[LAST];
  assign out_val_o = s_val[LAST];
  assign pk_vld_o  = s_vld[PEEK];
  assign pk_tag_o  = s_tag[PEEK];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_vld[0] |-> !prod[PW-1]); // R10

  AST_PAIR_FACTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_vld[0] && s_num[0]) |-> ($past(s_vld[0]) && !$past(s_num[0])
      && $past(s_id[0]) == s_id[0] && $past(s_tag[0]) == s_tag[0] && $stable(op_b))); // R4
endmodule

// File: rtl/gs_divider.sv
module gs_divider #(
  parameter int W          = 12,
  parameter int ID_W       = 4,
  parameter int MUL_STAGES = 4,
  parameter int SEED_IDX_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_i,
  input  logic [W-1:0]    opnd_i,
  output logic            ready_o,
  output logic            q_valid_o,
  output logic [W-1:0]    q_o,
  output logic [ID_W-1:0] q_id_o
);
  import gsd_pkg::*;

  localparam int ONE     = 1 << (W - 1);
  localparam int IDX_TOP = W - 3;

  logic            ex_vld, ex_num, pk_vld, recirc_now, recirc_next, acc;
  tag_t            ex_tag, pk_tag, en_tag;
  logic [ID_W-1:0] ex_id, en_id, id_q, pend_id_q;
  logic [W-1:0]    ex_val, en_val, en_fac, seed, fac_q;
  logic            en_vld, en_num, pend_q;

  gsd_seed_rom #(.W(W), .IDX_W(SEED_IDX_W)) u_seed (
    .idx_i (opnd_i[IDX_TOP -: SEED_IDX_W]),
    .fac_o (seed)
  );

  gsd_entry #(.W(W), .ID_W(ID_W)) u_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ex_vld_i   (ex_vld),
    .ex_tag_i   (ex_tag),
    .ex_num_i   (ex_num),
    .ex_id_i    (ex_id),
    .ex_val_i   (ex_val),
    .acc_i      (acc),
    .pend_i     (pend_q),
    .pend_id_i  (pend_id_q),
    .new_id_i   (id_q),
    .opnd_i     (opnd_i),
    .seed_i     (seed),
    .fac_hold_i (fac_q),
    .recirc_o   (recirc_now),
    .en_vld_o   (en_vld),
    .en_tag_o   (en_tag),
    .en_num_o   (en_num),
    .en_id_o    (en_id),
    .en_val_o   (en_val),
    .en_fac_o   (en_fac)
  );

  gsd_mul_pipe #(.W(W), .ID_W(ID_W), .STAGES(MUL_STAGES)) u_mul (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (en_vld),
    .in_tag_i  (en_tag),
    .in_num_i  (en_num),
    .in_id_i   (en_id),
    .in_a_i    (en_val),
    .in_b_i    (en_fac),
    .out_vld_o (ex_vld),
    .out_tag_o (ex_tag),
    .out_num_o (ex_num),
    .out_id_o  (ex_id),
    .out_val_o (ex_val),
    .pk_vld_o  (pk_vld),
    .pk_tag_o  (pk_tag)
  );

  // first stage must be free now (for D) and next cycle (for N)
  assign recirc_next = pk_vld && (pk_tag != TAG_LAST);
  assign ready_o     = !pend_q && !recirc_now && !recirc_next;
  assign acc         = cmd_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      pend_id_q <= '0;
      id_q      <= '0;
      fac_q     <= '0;
    end else begin
      pend_q <= acc;
      if (acc) begin
        pend_id_q <= id_q;
        id_q      <= id_q + 1'b1;
      end
      fac_q <= en_fac;
    end
  end

  assign q_valid_o = ex_vld && ex_num && (ex_tag == TAG_LAST);
  assign q_o       = ex_val;
  assign q_id_o    = ex_id;

  AST_READY_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !ready_o); // R2

  AST_SEED_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_vld && !ex_num && ex_tag == TAG_FIRST) |->
      (int'(ex_val) >= ONE - ONE / 8 - 2 && int'(ex_val) <= ONE + ONE / 16)); // R3

  AST_CONVERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_vld && !ex_num && ex_tag == TAG_LAST) |->
      (int'(ex_val) >= ONE - 8 && int'(ex_val) <= ONE)); // R5
endmodule

// File: tb/gs_divider_tb.sv
module gs_divider_tb;
  localparam int W    = 12;
  localparam int ID_W = 4;
  localparam int L    = 4;
  localparam int LAT  = 3 * L + 1;
  localparam int WDOG = 100000;

  typedef struct {
    int due;
    int id;
    int n;
    int d;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd = 1'b0;
  logic [W-1:0]    opnd = '0;
  logic            ready;
  logic            q_valid;
  logic [W-1:0]    q;
  logic [ID_W-1:0] q_id;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t eq[$];
  int jd[$], jn[$], jg[$];
  bit busy [0:16383];

  always #10 clk = ~clk;

  gs_divider #(.W(W), .ID_W(ID_W), .MUL_STAGES(L)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cmd_i     (cmd),
    .opnd_i    (opnd),
    .ready_o   (ready),
    .q_valid_o (q_valid),
    .q_o       (q),
    .q_id_o    (q_id)
  );

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  task automatic add_job(int d, int n, int gap);
    jd.push_back(d);
    jn.push_back(n);
    jg.push_back(gap);
  endtask

  initial begin
    int cyc, accepted, gapc, pend_nv, tail;
    bit pend, holding, exp_rdy, exp_v;
    real exact, err;
    exp_t e;

    // directed: worked example, range corners (R10), one denominator per seed interval (R3, R5)
    add_job(1621, 1450, 0);
    add_job(1025, 1024, 3);
    add_job(2047, 2046, 0);
    add_job(2047, 1024, 0);
    for (int k = 0; k < 8; k++) add_job(1024 + 128 * k + 64, 1024 + 64 * k + 16, k % 3);
    // back-to-back bursts to load the loop (R8, R9, R4)
    for (int i = 0; i < 40; i++) begin
      int d;
      d = 1025 + int'($urandom_range(1022));
      add_job(d, 1024 + int'($urandom_range(d - 1025)), 0);
    end
    for (int i = 0; i < 40; i++) begin
      int d;
      d = 1025 + int'($urandom_range(1022));
      add_job(d, 1024 + int'($urandom_range(d - 1025)), int'($urandom_range(8)));
    end

    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    chk(q_valid == 1'b0, "R1", "q_valid in reset", int'(q_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    chk(q_valid == 1'b0, "R1", "q_valid after reset", int'(q_valid), 0);

    cyc = 0; accepted = 0; gapc = 0; pend = 0; holding = 0; pend_nv = 0; tail = 0;
    while (cyc < 16000 && tail < 2 * LAT) begin
      // compare against the schedule model
      exp_rdy = !busy[cyc + 1] && !busy[cyc + 2];
      chk(ready == exp_rdy, "R8", "ready", int'(ready), int'(exp_rdy));
      if (pend) chk(ready == 1'b0, "R2", "ready in numerator cycle", int'(ready), 0);
      exp_v = (eq.size() > 0) && (eq[0].due == cyc);
      chk(q_valid == exp_v, "R6", "q_valid", int'(q_valid), int'(exp_v));
      if (exp_v) begin
        e = eq.pop_front();
        if (q_valid) begin
          exact = real'(e.n) / real'(e.d) * 2048.0;
          err = real'(q) - exact;
          chk(err >= -6.0 && err <= 2.0, "R7", "quotient", int'(q), int'(exact));
          chk(int'(q_id) == e.id, "R9", "quotient id", int'(q_id), e.id);
        end
      end

      // drive
      if (pend) begin
        cmd = 1'b0;
        opnd = W'(pend_nv);
        pend = 0;
      end else begin
        if (!holding && jd.size() > 0) begin
          if (gapc >= jg[0]) holding = 1;
          else gapc++;
        end
        if (holding) begin
          cmd = 1'b1;
          opnd = W'(jd[0]);
          if (ready) begin
            e.due = cyc + LAT;
            e.id = accepted % (1 << ID_W);
            e.d = jd[0];
            e.n = jn[0];
            eq.push_back(e);
            for (int p = 0; p < 3; p++) begin
              busy[cyc + 1 + p * L] = 1'b1;
              busy[cyc + 2 + p * L] = 1'b1;
            end
            accepted++;
            pend_nv = jn[0];
            pend = 1;
            holding = 0;
            gapc = 0;
            void'(jd.pop_front());
            void'(jn.pop_front());
            void'(jg.pop_front());
          end
        end else begin
          cmd = 1'b0;
          opnd = '0;
        end
      end
      if (jd.size() == 0 && eq.size() == 0 && !pend && !holding) tail++;
      cyc++;
      @(negedge clk);
    end
    chk(eq.size() == 0, "R6", "quotients outstanding", eq.size(), 0);
    chk(accepted == 92, "R2", "accepted commands", accepted, 92);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R6 act=%0d exp=%0d", WDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule